// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers single-cycle completion pulses from a set of DMA channel sources and folds them into one interrupt line for the processor. Each pulse sets a sticky pending bit. A per-source mask bit decides whether that pending bit may contribute to the interrupt. A mask bit of 1 blocks its source and a mask bit of 0 lets it through.

Software reaches the block through a simple register port with a write strobe, a byte address, write data and combinational read data. The mask can be rewritten as a whole. It can also be changed one bit at a time, without a read-modify-write, through a set alias and a clear alias. Pending bits are retired either selectively, through a write-one-to-acknowledge register, or all together by any write to a clear-all register. Two read-only views return the pending bits: one with the mask applied and one without.

With the default 16 sources, the source bit order is fixed:

| Bits | Sources |
|------|---------|
| 0, 1 | SDIO read, SDIO write |
| 2, 3 | application SPI read, application SPI write |
| 4, 5 | host SPI read, host SPI write |
| 6, 7 | shared SPI read, shared SPI write |
| 8 | camera threshold |
| 9 | camera FIFO empty |
| 10, 11 | audio-serial read, audio-serial write |
| 15:12 | four ADC write channels |

Top module: `xfer_done_irq`

Register offsets (byte addresses):

| Offset | Access | Function |
|--------|--------|----------|
| 0x00 | read/write | mask |
| 0x04 | write only | mask set |
| 0x08 | write only | mask clear |
| 0x0C | write only | clear all pending |
| 0x10 | write only | acknowledge |
| 0x14 | read only | masked status |
| 0x18 | read only | raw status |

## Requirements
- R1: After reset every mask bit is 1, no bit is pending and irq_o is 0.
- R2: A 1 on done_i[i] for one cycle sets pending bit i on the next clock edge. The bit stays set until an acknowledge or a clear-all removes it. Pending bits read at offset 0x18, source i at data bit i.
- R3: A write to offset 0x00 replaces the whole mask with the low NUM_SRC data bits, and a read of 0x00 returns the mask. Mask bit 1 disables the source.
- R4: Writing 1 to data bit i at offset 0x04 sets mask bit i. Data bits written as 0 leave their mask bits unchanged.
- R5: Writing 1 to data bit i at offset 0x08 clears mask bit i. Data bits written as 0 leave their mask bits unchanged.
- R6: Writing 1 to data bit i at offset 0x10 clears pending bit i. Data bits written as 0 leave their pending bits unchanged.
- R7: Any write to offset 0x0C clears every pending bit, whatever the data value.
- R8: A read of offset 0x14 returns pending AND NOT mask, one bit per source. Reads of 0x14 or 0x18 change no state.
- R9: irq_o is 1 exactly when at least one bit of the masked status is 1. It follows the state registers in the same cycle in the default variant (IRQ_REG = 0).
- R10: A done pulse on a source wins over an acknowledge or a clear-all that lands in the same cycle, so the bit is pending afterwards.
- R11: Offsets other than 0x00, 0x14 and 0x18 read as 0, and this includes the write-only aliases. Writes to unmapped offsets or to the read-only views change no state. Read-data bits above NUM_SRC are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | NUM_SRC | One-cycle completion pulses, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hazard that matters is a completion pulse that arrives in the same cycle as a register write that retires pending bits, either an acknowledge of the same bit or a clear-all. Directed steps drive a pulse together with each kind of retiring write, on the same source. The bench then checks that the raw view still shows the bit and that the interrupt follows the mask. Random cycles then overlap pulses with every kind of register write, and each result is judged against a bench model in which a pulse always wins.

// File: rtl/xdi_pkg.sv
package xdi_pkg;

   // Byte offsets of the register map
   localparam int unsigned OFS_MASK   = 32'h00;
   localparam int unsigned OFS_MSET   = 32'h04;
   localparam int unsigned OFS_MCLR   = 32'h08;
   localparam int unsigned OFS_CLRALL = 32'h0C;
   localparam int unsigned OFS_ACK    = 32'h10;
   localparam int unsigned OFS_STMSK  = 32'h14;
   localparam int unsigned OFS_STRAW  = 32'h18;

   // Narrowest address that still reaches the highest offset
   localparam int unsigned MIN_ADDR_W = 5;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MASK,
      SEL_MSET,
      SEL_MCLR,
      SEL_CLRALL,
      SEL_ACK,
      SEL_STMSK,
      SEL_STRAW
   } xdi_sel_e;

endpackage

// File: rtl/xdi_regif.sv
module xdi_regif
   import xdi_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [NUM_SRC-1:0] pend_q,
   input  logic [NUM_SRC-1:0] mask_q,
   input  logic [NUM_SRC-1:0] masked,
   output logic               wr_mask,
   output logic               wr_mset,
   output logic               wr_mclr,
   output logic               wr_clr_all,
   output logic               wr_ack,
   output logic [NUM_SRC-1:0] wbits,
   output logic [DATA_W-1:0]  bus_rdata
);

   xdi_sel_e sel;
   logic     unused_wdata;

   // Full-address compare: unaligned or out-of-map addresses decode to none
   always_comb begin
      sel = SEL_NONE;
      if      (bus_addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
      else if (bus_addr == ADDR_W'(OFS_MSET))   sel = SEL_MSET;
      else if (bus_addr == ADDR_W'(OFS_MCLR))   sel = SEL_MCLR;
      else if (bus_addr == ADDR_W'(OFS_CLRALL)) sel = SEL_CLRALL;
      else if (bus_addr == ADDR_W'(OFS_ACK))    sel = SEL_ACK;
      else if (bus_addr == ADDR_W'(OFS_STMSK))  sel = SEL_STMSK;
      else if (bus_addr == ADDR_W'(OFS_STRAW))  sel = SEL_STRAW;
   end

   assign wr_mask    = bus_we && (sel == SEL_MASK);
   assign wr_mset    = bus_we && (sel == SEL_MSET);
   assign wr_mclr    = bus_we && (sel == SEL_MCLR);
   assign wr_clr_all = bus_we && (sel == SEL_CLRALL);
   assign wr_ack     = bus_we && (sel == SEL_ACK);
   assign wbits      = bus_wdata[NUM_SRC-1:0];

   // Bits above NUM_SRC carry no function
   assign unused_wdata = ^bus_wdata;

   // Read side has no effect on state; write-only aliases return zero
   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_MASK:  bus_rdata[NUM_SRC-1:0] = mask_q;
         SEL_STMSK: bus_rdata[NUM_SRC-1:0] = masked;
         SEL_STRAW: bus_rdata[NUM_SRC-1:0] = pend_q;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/xdi_mask.sv
module xdi_mask #(
   parameter int NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_ni,
   input  logic               wr_mask,
   input  logic               wr_mset,
   input  logic               wr_mclr,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask_q
);

   // One flop per source; only one write strobe can be active per cycle
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_q[i] <= 1'b1;
         end else if (wr_mask) begin
            mask_q[i] <= wbits[i];
         end else if (wr_mset && wbits[i]) begin
            mask_q[i] <= 1'b1;
         end else if (wr_mclr && wbits[i]) begin
            mask_q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/xdi_pend.sv
module xdi_pend #(
   parameter int NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] done_i,
   input  logic               wr_ack,
   input  logic               wr_clr_all,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] pend_q
);

   // Sticky status; a fresh pulse takes priority over any retirement
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q[i] <= 1'b0;
         end else if (done_i[i]) begin
            pend_q[i] <= 1'b1;
         end else if (wr_clr_all || (wr_ack && wbits[i])) begin
            pend_q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/xdi_irq_out.sv
module xdi_irq_out #(
   parameter int NUM_SRC = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] pend_q,
   input  logic [NUM_SRC-1:0] mask_q,
   output logic [NUM_SRC-1:0] masked,
   output logic               irq_o
);

   assign masked = pend_q & ~mask_q;

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= |masked;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = |masked;
   end

endmodule

// File: rtl/xfer_done_irq.sv
module xfer_done_irq
   import xdi_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] done_i,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);

   // Elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("xfer_done_irq: NUM_SRC must be between 1 and DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("xfer_done_irq: ADDR_W too narrow for the register map");
   end

   logic               wr_mask;
   logic               wr_mset;
   logic               wr_mclr;
   logic               wr_clr_all;
   logic               wr_ack;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] masked;

   xdi_regif #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_regif (
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .pend_q     (pend_q),
      .mask_q     (mask_q),
      .masked     (masked),
      .wr_mask    (wr_mask),
      .wr_mset    (wr_mset),
      .wr_mclr    (wr_mclr),
      .wr_clr_all (wr_clr_all),
      .wr_ack     (wr_ack),
      .wbits      (wbits),
      .bus_rdata  (bus_rdata)
   );

   xdi_mask #(
      .NUM_SRC (NUM_SRC)
   ) u_mask (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .wr_mask (wr_mask),
      .wr_mset (wr_mset),
      .wr_mclr (wr_mclr),
      .wbits   (wbits),
      .mask_q  (mask_q)
   );

   xdi_pend #(
      .NUM_SRC (NUM_SRC)
   ) u_pend (
      .clk        (clk),
      .rst_ni     (rst_ni),
      .done_i     (done_i),
      .wr_ack     (wr_ack),
      .wr_clr_all (wr_clr_all),
      .wbits      (wbits),
      .pend_q     (pend_q)
   );

   xdi_irq_out #(
      .NUM_SRC (NUM_SRC),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk    (clk),
      .rst_ni (rst_ni),
      .pend_q (pend_q),
      .mask_q (mask_q),
      .masked (masked),
      .irq_o  (irq_o)
   );

endmodule

// File: rtl/xfer_done_irq_chk.sv
module xfer_done_irq_chk #(
   parameter int NUM_SRC = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] done_i,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic               wr_ack,
   input logic               wr_clr_all,
   input logic               wr_mset,
   input logic               wr_mclr,
   input logic [NUM_SRC-1:0] wbits
);

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_ni |=> (mask_q == '1 && pend_q == '0));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_ni)
      (!wr_ack && !wr_clr_all) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      wr_mset |=> ((mask_q & $past(wbits)) == $past(wbits)));

   assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_ni)
      wr_mclr |=> ((mask_q & $past(wbits)) == '0));

   assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_clr_all && done_i == '0) |=> (pend_q == '0));

   assert_done_wins_R10: assert property (@(posedge clk) disable iff (!rst_ni)
      (done_i != '0) |=> ((pend_q & $past(done_i)) == $past(done_i)));

   if (IRQ_REG) begin : g_irq_reg
      assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ni)
         ((pend_q & ~mask_q) == '0) |=> !irq_o);
   end else begin : g_irq_comb
      assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ni)
         (pend_q == '0) |-> !irq_o);
   end

endmodule

bind xfer_done_irq xfer_done_irq_chk #(
   .NUM_SRC (NUM_SRC),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_ni     (rst_ni),
   .done_i     (done_i),
   .irq_o      (irq_o),
   .pend_q     (pend_q),
   .mask_q     (mask_q),
   .wr_ack     (wr_ack),
   .wr_clr_all (wr_clr_all),
   .wr_mset    (wr_mset),
   .wr_mclr    (wr_mclr),
   .wbits      (wbits)
);

// File: tb/sim_xfer_done_irq.sv
module sim_xfer_done_irq;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 16;
   localparam int DW = 32;
   localparam int AW = 8;

   localparam logic [7:0] A_MASK = 8'h00, A_MSET = 8'h04, A_MCLR = 8'h08,
                          A_CLR  = 8'h0C, A_ACK  = 8'h10, A_STM  = 8'h14,
                          A_RAW  = 8'h18;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic [NS-1:0] done_i = '0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_o;

   int unsigned   vectors = 0;
   int unsigned   errs = 0;
   bit            finished = 1'b0;
   logic [NS-1:0] exp_pend = '0;
   logic [NS-1:0] exp_mask = '1;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfer_done_irq #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk       (clk),
      .rst_ni    (rst_ni),
      .done_i    (done_i),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   function automatic logic [NS-1:0] nxt_pend(logic [NS-1:0] p, logic [NS-1:0] d,
                                              logic we, logic [7:0] a, logic [DW-1:0] wd);
      logic [NS-1:0] r;
      r = p;
      if (we && a == A_CLR) r = '0;
      if (we && a == A_ACK) r = r & ~wd[NS-1:0];
      return r | d;
   endfunction

   function automatic logic [NS-1:0] nxt_mask(logic [NS-1:0] m, logic we,
                                              logic [7:0] a, logic [DW-1:0] wd);
      logic [NS-1:0] r;
      r = m;
      if (we && a == A_MASK) r = wd[NS-1:0];
      if (we && a == A_MSET) r = m | wd[NS-1:0];
      if (we && a == A_MCLR) r = m & ~wd[NS-1:0];
      return r;
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; inputs are held through the next rising edge
   task automatic drive(logic [NS-1:0] d, logic we, logic [7:0] a, logic [DW-1:0] wd);
      done_i = d; bus_we = we; bus_addr = a; bus_wdata = wd;
      @(posedge clk);
      exp_pend = nxt_pend(exp_pend, d, we, a, wd);
      exp_mask = nxt_mask(exp_mask, we, a, wd);
      @(negedge clk);
      done_i = '0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [DW-1:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic check_model();
      logic [DW-1:0] v;
      rd(A_RAW, v);  check("R2", v, DW'(exp_pend));
      rd(A_STM, v);  check("R8", v, DW'(exp_pend & ~exp_mask));
      rd(A_MASK, v); check("R3", v, DW'(exp_mask));
      check("R9", DW'(irq_o), DW'(|(exp_pend & ~exp_mask)));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      void'($urandom(32'd5171));
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_MASK, v); check("R1 mask", v, 32'h0000_FFFF);
      rd(A_RAW, v);  check("R1 pend", v, 32'h0);
      check("R1 irq", DW'(irq_o), 32'h0);

      // R3 whole-mask write
      drive('0, 1'b1, A_MASK, 32'hABCD_00F0);
      rd(A_MASK, v); check("R3", v, 32'h0000_00F0);

      // R2 pulse sets sticky bits; R8 masked view; R9 irq
      drive(16'h0011, 1'b0, A_MASK, '0);
      rd(A_RAW, v); check("R2", v, 32'h0000_0011);
      rd(A_STM, v); check("R8", v, 32'h0000_0001);
      check("R9", DW'(irq_o), 32'h1);
      drive('0, 1'b0, A_RAW, '0);
      drive('0, 1'b0, A_STM, '0);
      rd(A_RAW, v); check("R2 sticky after reads", v, 32'h0000_0011);

      // R4 set alias
      drive('0, 1'b1, A_MSET, 32'h0);
      rd(A_MASK, v); check("R4 zeros", v, 32'h0000_00F0);
      drive('0, 1'b1, A_MSET, 32'h0000_0100);
      rd(A_MASK, v); check("R4", v, 32'h0000_01F0);

      // R5 clear alias
      drive('0, 1'b1, A_MCLR, 32'h0);
      rd(A_MASK, v); check("R5 zeros", v, 32'h0000_01F0);
      drive('0, 1'b1, A_MCLR, 32'h0000_0030);
      rd(A_MASK, v); check("R5", v, 32'h0000_01C0);

      // R6 acknowledge
      drive('0, 1'b1, A_ACK, 32'h0);
      rd(A_RAW, v); check("R6 zeros", v, 32'h0000_0011);
      drive('0, 1'b1, A_ACK, 32'h0000_0001);
      rd(A_RAW, v); check("R6", v, 32'h0000_0010);

      // R10 pulse and acknowledge of the same bit in one cycle
      drive(16'h0010, 1'b1, A_ACK, 32'h0000_0010);
      rd(A_RAW, v); check("R10 ack", v, 32'h0000_0010);

      // R10 pulse with clear-all; R7 clear-all ignores data
      drive(16'h8000, 1'b1, A_CLR, 32'h0);
      rd(A_RAW, v); check("R10 clrall", v, 32'h0000_8000);
      drive('0, 1'b1, A_CLR, 32'h1234_5678);
      rd(A_RAW, v); check("R7", v, 32'h0);
      check("R9 idle", DW'(irq_o), 32'h0);

      // R8/R9 pending but fully masked
      drive('0, 1'b1, A_MASK, 32'h0000_FFFF);
      drive(16'h0004, 1'b0, A_MASK, '0);
      rd(A_STM, v); check("R8 masked out", v, 32'h0);
      check("R9 masked out", DW'(irq_o), 32'h0);

      // R11 unmapped and write-only reads, ignored writes
      rd(8'h1C, v); check("R11 rd 1C", v, 32'h0);
      rd(8'h03, v); check("R11 rd 03", v, 32'h0);
      rd(8'hFF, v); check("R11 rd FF", v, 32'h0);
      rd(A_ACK, v); check("R11 rd ack", v, 32'h0);
      drive('0, 1'b1, A_RAW, 32'hFFFF_FFFF);
      drive('0, 1'b1, A_STM, 32'h0);
      drive('0, 1'b1, 8'h40, 32'hFFFF_FFFF);
      drive('0, 1'b1, 8'h11, 32'hFFFF_FFFF);
      rd(A_RAW, v);  check("R11 raw kept", v, 32'h0000_0004);
      rd(A_MASK, v); check("R11 mask kept", v, 32'h0000_FFFF);

      // Random mix against the bench model
      for (int n = 0; n < 600; n++) begin
         logic [NS-1:0] d;
         logic [7:0]    a;
         logic          we;
         int unsigned   op;
         d  = ($urandom % 3 == 0) ? NS'($urandom) & NS'($urandom) : '0;
         op = $urandom % 9;
         we = 1'b1;
         case (op)
            0: a = A_MASK;
            1: a = A_MSET;
            2: a = A_MCLR;
            3: a = ($urandom % 3 == 0) ? A_CLR : A_ACK;
            4: a = A_ACK;
            5: a = A_RAW;
            6: a = 8'h20 + 8'($urandom % 32);
            default: begin a = A_STM; we = 1'b0; end
         endcase
         drive(d, we, a, $urandom);
         check_model();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule